// File: doc/BRIEF.md
# Reset Mode-Select and Power-Up Controller

This block chooses the operating mode of a mixed-signal device once its reset is released, and it gates the internal power of that device. While reset is held, the block keeps everything powered down and refuses control-port writes. After release it opens a timing window of a fixed number of reference-clock cycles. A register write that arrives inside that window commits the device to software mode. If the window runs out with no write, a crystal-present strap picks the mode. With the strap high the device goes to software mode and its system-clock output is enabled. With the strap low the device goes to hardware mode and powers itself up.

In software mode the device stays powered down until software clears a global power-down bit held in the register store. The write that caused entry to software mode cannot clear that bit. Clearing the bit raises a single power-enable output one cycle later. Setting the bit again drops it. The chosen mode is latched until reset is asserted again. Stored register values can be read back through a registered read port.

Top module: `rmp_powerup_ctrl`

## Requirements
- R1: While `rst` is high: `pwr_en`=0, `pdn_flag`=1, `mode_sw`=0, `mode_hw`=0 and `sysclk_oe`=0. A write presented while `rst` is high is not stored, and every register reads 0 afterwards except the power-down register, which reads with only its power-down bit set.
- R2: Call the first clock edge with `rst` low edge 1. A write with `wr_en`=1 on any edge from 1 to `WINDOW_CYC` sets `mode_sw` after that same edge.
- R3: The write that commits software mode is stored, but bit `PDN_BIT` of register `PDN_ADDR` is forced to 1. `pdn_flag` stays 1 and `pwr_en` stays 0.
- R4: In software mode, while `pdn_flag`=1, writes to any address are stored and `pwr_en` stays 0.
- R5: In software mode, a write to `PDN_ADDR` with bit `PDN_BIT`=0 clears `pdn_flag` after that edge. `pwr_en` rises one edge later.
- R6: A later write to `PDN_ADDR` with bit `PDN_BIT`=1 sets `pdn_flag` again. `pwr_en` falls one edge later.
- R7: If no write arrives by edge `WINDOW_CYC` and `xtal_present`=0 at that edge, `mode_hw` is set after edge `WINDOW_CYC`. `pwr_en` rises one edge later, and `sysclk_oe` stays 0.
- R8: If no write arrives and `xtal_present`=1 at edge `WINDOW_CYC`, both `mode_sw` and `sysclk_oe` are set after that edge. `pdn_flag` stays 1 and `pwr_en` stays 0.
- R9: If software mode was already entered by a write and `xtal_present`=1, `sysclk_oe` still asserts after edge `WINDOW_CYC` and not before. The mode does not change.
- R10: A write on edge `WINDOW_CYC` takes priority over window expiry. The result is software mode, not hardware mode.
- R11: Once a mode is chosen, it holds until `rst` is asserted. In hardware mode, writes are ignored and stored values do not change.
- R12: `rd_data` shows the register at `rd_addr` one edge after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high device reset |
| xtal_present | input | 1 | Strap: crystal fitted on the oscillator pins |
| wr_en | input | 1 | Control-port register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Registered read data |
| pdn_flag | output | 1 | Global power-down bit as stored |
| pwr_en | output | 1 | Power-enable to the internal blocks |
| mode_sw | output | 1 | Software mode committed |
| mode_hw | output | 1 | Hardware mode committed |
| sysclk_oe | output | 1 | System-clock output enable |

## Verification
The sharpest collision is a control-port write that lands on the final cycle of the timing window, the same edge on which expiry would otherwise commit hardware mode. The bench places the strobe exactly on edge `WINDOW_CYC` with the strap low. It then judges that software mode is taken, that hardware mode never appears, and that power stays off. A second overlap is a crystal-driven clock enable at window end after a write has already chosen the mode. This is provoked by an early write with the strap high. The bench checks that the clock enable appears on exactly the expiry edge while the mode stays unchanged.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  typedef enum logic [1:0] {
    MS_WAIT = 2'd0,
    MS_SW   = 2'd1,
    MS_HW   = 2'd2
  } mode_state_t;

endpackage

// File: rtl/rmp_window_timer.sv
module rmp_window_timer #(
  parameter int WINDOW_CYC = 120000
) (
  input  logic clk,
  input  logic rst,
  output logic win_last
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_last = run_q && (cnt_q == LAST);

  // R7 / R8: the window ends exactly once per reset release
  a_r7_single_expiry: assert property (@(posedge clk) disable iff (rst)
    win_last |=> !win_last);

endmodule

// File: rtl/rmp_mode_fsm.sv
module rmp_mode_fsm
  import rmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic win_last,
  input  logic xtal_present,
  output logic wr_accept,
  output logic trigger_wr,
  output logic mode_sw,
  output logic mode_hw,
  output logic sysclk_oe
);
  mode_state_t state_q;
  logic        clk_oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= MS_WAIT;
      clk_oe_q <= 1'b0;
    end else begin
      if (state_q == MS_WAIT) begin
        if (wr_en)         state_q <= MS_SW;
        else if (win_last) state_q <= xtal_present ? MS_SW : MS_HW;
      end
      if (win_last && xtal_present) clk_oe_q <= 1'b1;
    end
  end

  assign wr_accept  = wr_en && (state_q != MS_HW);
  assign trigger_wr = wr_en && (state_q == MS_WAIT);
  assign mode_sw    = (state_q == MS_SW);
  assign mode_hw    = (state_q == MS_HW);
  assign sysclk_oe  = clk_oe_q;

  a_r2_write_commits: assert property (@(posedge clk) disable iff (rst)
    (state_q == MS_WAIT && wr_en) |=> (state_q == MS_SW));

  a_r11_mode_latched: assert property (@(posedge clk) disable iff (rst)
    (state_q != MS_WAIT) |=> (state_q == $past(state_q)));

  a_r8_clk_needs_strap: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_oe_q) |-> ($past(xtal_present) && $past(win_last)));

endmodule

// File: rtl/rmp_cfg_regs.sv
module rmp_cfg_regs #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int PDN_ADDR = 5,
  parameter int PDN_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          force_pdn,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pdn_flag
);
  localparam int          NREG     = 2 ** AW;
  localparam logic [DW-1:0] PDN_MASK = DW'(1) << PDN_BIT;
  localparam logic [AW-1:0] PDN_A    = AW'(PDN_ADDR);

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] rd_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RVAL = (i == PDN_ADDR) ? PDN_MASK : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= RVAL;
      end else if (we && wr_addr == AW'(i)) begin
        regs_q[i] <= (force_pdn && i == PDN_ADDR) ? (wr_data | PDN_MASK) : wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= regs_q[rd_addr];
  end

  assign rd_data  = rd_q;
  assign pdn_flag = regs_q[PDN_A][PDN_BIT];

  a_r3_trigger_keeps_pdn: assert property (@(posedge clk) disable iff (rst)
    (we && force_pdn) |=> pdn_flag);

  a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(pdn_flag));

endmodule

// File: rtl/rmp_powerup_ctrl.sv
module rmp_powerup_ctrl
  import rmp_pkg::*;
#(
  parameter int WINDOW_CYC = 120000,
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int PDN_ADDR   = 5,
  parameter int PDN_BIT    = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xtal_present,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pdn_flag,
  output logic          pwr_en,
  output logic          mode_sw,
  output logic          mode_hw,
  output logic          sysclk_oe
);
  logic win_last;
  logic wr_accept;
  logic trigger_wr;
  logic pwr_q;

  rmp_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .win_last (win_last)
  );

  rmp_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .win_last     (win_last),
    .xtal_present (xtal_present),
    .wr_accept    (wr_accept),
    .trigger_wr   (trigger_wr),
    .mode_sw      (mode_sw),
    .mode_hw      (mode_hw),
    .sysclk_oe    (sysclk_oe)
  );

  rmp_cfg_regs #(
    .AW(AW), .DW(DW), .PDN_ADDR(PDN_ADDR), .PDN_BIT(PDN_BIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_accept),
    .force_pdn (trigger_wr),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pdn_flag  (pdn_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) pwr_q <= 1'b0;
    else     pwr_q <= mode_hw || (mode_sw && !pdn_flag);
  end

  assign pwr_en = pwr_q;

  // R1: a reset edge leaves everything down
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pwr_en && pdn_flag && !mode_sw && !mode_hw && !sysclk_oe));

  // R5: power rises only one cycle after its cause
  a_r5_pwr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> ($past(mode_hw) || ($past(mode_sw) && !$past(pdn_flag))));

  // R6: setting power-down drops power on the next edge
  a_r6_pwr_drop: assert property (@(posedge clk) disable iff (rst)
    (mode_sw && pdn_flag) |=> !pwr_en);

  // R7: hardware mode never carries the crystal clock enable
  a_r7_hw_no_clk: assert property (@(posedge clk) disable iff (rst)
    mode_hw |-> !sysclk_oe);

  a_r11_one_mode: assert property (@(posedge clk) disable iff (rst)
    !(mode_sw && mode_hw));

endmodule

// File: tb/tb_rmp_powerup_ctrl.sv
module tb_rmp_powerup_ctrl;
  localparam int W  = 40;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PA = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xtal_present = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          pdn_flag, pwr_en, mode_sw, mode_hw, sysclk_oe;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rmp_powerup_ctrl #(.WINDOW_CYC(W), .AW(AW), .DW(DW), .PDN_ADDR(PA), .PDN_BIT(0)) dut (
    .clk(clk), .rst(rst), .xtal_present(xtal_present),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pdn_flag(pdn_flag), .pwr_en(pwr_en), .mode_sw(mode_sw),
    .mode_hw(mode_hw), .sysclk_oe(sysclk_oe)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic do_write(input int a, input int d);
    wr_addr = AW'(a);
    wr_data = DW'(d);
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int a, output int d);
    rd_addr = AW'(a);
    tick();
    d = int'(rd_data);
  endtask

  task automatic t_reset();
    int d;
    xtal_present = 1'b0;
    rst = 1'b1;
    tick(2);
    check("R1", "pwr_en", pwr_en, 0);
    check("R1", "pdn_flag", pdn_flag, 1);
    check("R1", "modes", {mode_sw, mode_hw}, 0);
    check("R1", "sysclk_oe", sysclk_oe, 0);
    wr_addr = 4'd2; wr_data = 8'h99; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    rst = 1'b0;
    do_read(2, d);
    check("R1", "write under reset dropped", d, 0);
    do_read(PA, d);
    check("R12", "pdn reg reset value", d, 1);
    check("R1", "read did not commit mode", mode_sw, 0);
  endtask

  task automatic t_sw_flow();
    int d;
    xtal_present = 1'b0;
    do_reset();
    tick(5);
    do_write(PA, 8'h00);
    check("R2", "mode_sw after write", mode_sw, 1);
    check("R3", "pdn kept set", pdn_flag, 1);
    tick();
    check("R3", "pwr_en off", pwr_en, 0);
    do_read(PA, d);
    check("R3", "trigger stored, pdn forced", d, 8'h01);
    do_write(2, 8'hA5);
    tick();
    check("R4", "pwr_en off after store", pwr_en, 0);
    do_read(2, d);
    check("R4", "stored value", d, 8'hA5);
    do_write(PA, 8'h40);
    check("R5", "pdn cleared", pdn_flag, 0);
    check("R5", "pwr_en not yet", pwr_en, 0);
    tick();
    check("R5", "pwr_en one later", pwr_en, 1);
    do_write(PA, 8'h41);
    check("R6", "pwr_en still up at edge", pwr_en, 1);
    tick();
    check("R6", "pwr_en dropped", pwr_en, 0);
    tick(W);
    check("R11", "mode_sw held past window", mode_sw, 1);
    check("R9", "no clock without strap", sysclk_oe, 0);
    do_write(PA, 8'h00);
    tick();
    check("R5", "power back up", pwr_en, 1);
    rst = 1'b1;
    tick();
    check("R1", "re-reset pwr_en", pwr_en, 0);
    check("R1", "re-reset pdn", pdn_flag, 1);
    check("R1", "re-reset modes", {mode_sw, mode_hw}, 0);
    rst = 1'b0;
    do_read(2, d);
    check("R1", "regs cleared", d, 0);
  endtask

  task automatic t_hw();
    int d;
    xtal_present = 1'b0;
    do_reset();
    tick(W - 1);
    check("R7", "no mode before expiry", {mode_sw, mode_hw}, 0);
    tick();
    check("R7", "mode_hw at expiry", mode_hw, 1);
    check("R7", "pwr_en not yet", pwr_en, 0);
    tick();
    check("R7", "pwr_en up", pwr_en, 1);
    check("R7", "sysclk_oe off", sysclk_oe, 0);
    do_write(3, 8'h77);
    do_read(3, d);
    check("R11", "hw write ignored", d, 0);
    check("R11", "mode_hw held", mode_hw, 1);
    check("R11", "mode_sw not set", mode_sw, 0);
  endtask

  task automatic t_xtal();
    xtal_present = 1'b1;
    do_reset();
    tick(W - 1);
    check("R8", "no mode before expiry", mode_sw, 0);
    check("R8", "clock off before expiry", sysclk_oe, 0);
    tick();
    check("R8", "mode_sw at expiry", mode_sw, 1);
    check("R8", "sysclk_oe at expiry", sysclk_oe, 1);
    check("R8", "pdn set", pdn_flag, 1);
    tick();
    check("R8", "pwr_en off", pwr_en, 0);
    xtal_present = 1'b0;
  endtask

  task automatic t_xtal_early();
    int d;
    xtal_present = 1'b1;
    do_reset();
    tick(2);
    do_write(1, 8'h3C);
    check("R9", "early write commits", mode_sw, 1);
    tick(W - 4);
    check("R9", "clock off before end", sysclk_oe, 0);
    tick();
    check("R9", "clock on at end", sysclk_oe, 1);
    check("R9", "mode unchanged", {mode_sw, mode_hw}, 2'b10);
    do_read(1, d);
    check("R9", "early write stored", d, 8'h3C);
    xtal_present = 1'b0;
  endtask

  task automatic t_last_edge();
    xtal_present = 1'b0;
    do_reset();
    tick(W - 1);
    do_write(7, 8'h00);
    check("R10", "write wins: mode_sw", mode_sw, 1);
    check("R10", "write wins: no hw", mode_hw, 0);
    tick();
    check("R10", "power stays off", pwr_en, 0);
    tick(3);
    check("R10", "still no hw", mode_hw, 0);
  endtask

  initial begin
    tick(20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sw_flow();
    t_hw();
    t_xtal();
    t_xtal_early();
    t_last_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule